// File: doc/BRIEF.md
# LFSR Divisor State Translator

This block converts a plain binary clock divisor into the encoding that an LFSR-based cycle counter expects, and converts such an encoding back into a binary divisor. The counter counts its coarse part with an 11-bit Galois LFSR, so a coarse count cannot be written directly: it has to be replaced by the LFSR state that lies the right number of steps from a fixed seed. The two least significant divisor bits form a fine field that passes through unchanged.

The translator keeps no table. A forward request walks the LFSR from its seed for a number of steps that follows from the coarse count and returns the state it reaches. An inverse request walks from the seed until the state in the request is met and turns the step count back into a divisor. One request is handled at a time. A request is taken while `req_ready` is high, and the result comes with a one-cycle `res_done` strobe and an error flag for divisors outside the range the counter can take.

Top module: `lfsr_div_xlate`

## Requirements
- R1: The LFSR is 11 bits wide, starts from seed 0x7ff, and on each step shifts right by one. When the old bit 0 was 1, it also XORs 0x500 into the shifted value. Table index k (1..2047) denotes the state reached after 2048−k steps, so index 2047 is 0x6ff and index 1 is the seed 0x7ff.
- R2: Forward request (`req_inverse`=0): coarse c = `req_data`[13:2] and fine f = `req_data`[1:0]. For 3 ≤ c ≤ 2049, `res_data` = {1'b0, state of index c−2, f} (state in bits [12:2], f in bits [1:0]) and `res_err`=0.
- R3: A forward request with c = 2 (index 0) gives `res_data` = f, so the state field is zero, and `res_err`=0.
- R4: A forward request with c < 2 or c ≥ 2050 gives `res_err`=1 and `res_data`=0.
- R5: Inverse request (`req_inverse`=1): state s = `req_data`[12:2]. For s ≠ 0, `res_data` = (k+2)·4 + f, where k is the index of s. `req_data`[13] is ignored.
- R6: An inverse request with s = 0 gives `res_data` = 8 + f and `res_err`=0.
- R7: An inverse request whose state is not met within 2047 steps gives `res_err`=1 and `res_data`=0. With the default taps every nonzero state is met, so inverse requests report `res_err`=0.
- R8: `req_ready` is high while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is then low until the result edge, and requests made while it is low are ignored.
- R9: `res_done` is a one-cycle pulse, and `res_data`/`res_err` change only on the edge that raises it. It comes 2048−k edges after the accepting edge for a forward index k ≥ 1 and for an inverse index k. For the cases of R3, R4 and R6 it comes on the accepting edge itself. No request is busy for more than 2047 cycles.
- R10: During and straight after reset, `req_ready`=1, `res_done`=0, `res_err`=0 and `res_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_inverse | input | 1 | 0 = binary to LFSR encoding, 1 = LFSR encoding to binary |
| req_data | input | 14 | Divisor (forward) or encoded value (inverse) |
| req_ready | output | 1 | Idle and able to take a request |
| res_data | output | 14 | Translated value |
| res_err | output | 1 | Out of range or state not found |
| res_done | output | 1 | One-cycle result strobe |

## Verification
The assertions check on every cycle that the handshake holds: a busy period starts only from a request, the strobe only comes while idle, the result holds between strobes, an error result reads zero, and no busy period runs past the walk bound. The exact mapping between divisors and LFSR states, the special zero cases, the range limits and the exact latency per index can only be shown by the bench. It compares sweeps of indices at both ends of the sequence, and chosen mid-range points, against a model sequence it computes itself.

// File: rtl/lfsr_div_xlate_pkg.sv
package lfsr_div_xlate_pkg;
  typedef enum logic [1:0] {
    XL_IDLE = 2'd0,
    XL_FWD  = 2'd1,
    XL_INV  = 2'd2
  } xl_mode_e;
endpackage

// File: rtl/lfsr_div_xlate_decode.sv
module lfsr_div_xlate_decode #(
  parameter int LW  = 11,
  parameter int FW  = 2,
  parameter int OFS = 2,
  parameter int DW  = LW + FW + 1
) (
  input  logic [DW-1:0] data,
  output logic [LW-1:0] idx,
  output logic [FW-1:0] fine,
  output logic          oor,
  output logic          idx_zero,
  output logic [LW:0]   fwd_steps,
  output logic [LW-1:0] st_field,
  output logic          st_zero
);
  localparam int CW = DW - FW;
  localparam logic [LW:0] TBL_N = (LW+1)'(1 << LW);

  logic [CW-1:0] coarse;

  always_comb begin
    coarse    = data[DW-1:FW];
    fine      = data[FW-1:0];
    oor       = (int'(coarse) < OFS) || (int'(coarse) >= OFS + (1 << LW));
    idx       = LW'(coarse - CW'(OFS));
    idx_zero  = (idx == '0);
    fwd_steps = TBL_N - {1'b0, idx};
    st_field  = data[LW+FW-1:FW];
    st_zero   = (st_field == '0);
  end
endmodule

// File: rtl/lfsr_div_xlate_walker.sv
module lfsr_div_xlate_walker #(
  parameter int          LW   = 11,
  parameter logic [LW-1:0] SEED = 11'h7ff,
  parameter logic [LW-1:0] TAPS = 11'h500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  output logic [LW-1:0] cur,
  output logic [LW-1:0] nxt,
  output logic [LW:0]   cnt
);
  always_comb begin
    nxt = cur >> 1;
    if (cur[0]) nxt = (cur >> 1) ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cur <= SEED;
      cnt <= '0;
    end else if (adv) begin
      cur <= nxt;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lfsr_div_xlate.sv
module lfsr_div_xlate
  import lfsr_div_xlate_pkg::*;
#(
  parameter int            LFSR_W     = 11,
  parameter int            FINE_W     = 2,
  parameter int            COARSE_OFS = 2,
  parameter logic [LFSR_W-1:0] SEED   = 11'h7ff,
  parameter logic [LFSR_W-1:0] TAPS   = 11'h500,
  localparam int           DATA_W     = LFSR_W + FINE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_inverse,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err,
  output logic              res_done
);
  localparam logic [LFSR_W:0] TBL_N  = (LFSR_W+1)'(1 << LFSR_W);
  localparam logic [LFSR_W:0] PERIOD = TBL_N - 1'b1;
  localparam logic [LFSR_W:0] OFS_V  = (LFSR_W+1)'(COARSE_OFS);

  xl_mode_e            mode;
  logic [LFSR_W-1:0]   d_idx, d_st;
  logic [FINE_W-1:0]   d_fine;
  logic                d_oor, d_idx_zero, d_st_zero;
  logic [LFSR_W:0]     d_steps;

  logic [LFSR_W-1:0]   w_cur, w_nxt;
  logic [LFSR_W:0]     w_cnt, w_cnt_n;

  logic [LFSR_W:0]     tgt_steps;
  logic [LFSR_W-1:0]   tgt_state;
  logic [FINE_W-1:0]   fine_q;

  logic [LFSR_W:0]     inv_idx;
  logic [LFSR_W:0]     inv_coarse;

  lfsr_div_xlate_decode #(
    .LW(LFSR_W), .FW(FINE_W), .OFS(COARSE_OFS), .DW(DATA_W)
  ) dec_i (
    .data(req_data), .idx(d_idx), .fine(d_fine), .oor(d_oor),
    .idx_zero(d_idx_zero), .fwd_steps(d_steps), .st_field(d_st),
    .st_zero(d_st_zero)
  );

  lfsr_div_xlate_walker #(
    .LW(LFSR_W), .SEED(SEED), .TAPS(TAPS)
  ) walk_i (
    .clk(clk), .rst(rst), .load(mode == XL_IDLE),
    .adv(mode != XL_IDLE), .cur(w_cur), .nxt(w_nxt), .cnt(w_cnt)
  );

  always_comb begin
    w_cnt_n    = w_cnt + 1'b1;
    inv_idx    = TBL_N - w_cnt_n;
    inv_coarse = inv_idx + OFS_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= XL_IDLE;
      req_ready <= 1'b1;
      res_done  <= 1'b0;
      res_err   <= 1'b0;
      res_data  <= '0;
      tgt_steps <= '0;
      tgt_state <= '0;
      fine_q    <= '0;
    end else begin
      res_done <= 1'b0;
      unique case (mode)
        XL_IDLE: begin
          if (req_valid) begin
            fine_q    <= d_fine;
            tgt_steps <= d_steps;
            tgt_state <= d_st;
            if (!req_inverse) begin
              if (d_oor) begin
                res_data <= '0;
                res_err  <= 1'b1;
                res_done <= 1'b1;
              end else if (d_idx_zero) begin
                res_data <= DATA_W'(d_fine);
                res_err  <= 1'b0;
                res_done <= 1'b1;
              end else begin
                mode      <= XL_FWD;
                req_ready <= 1'b0;
              end
            end else begin
              if (d_st_zero) begin
                res_data <= {OFS_V, d_fine};
                res_err  <= 1'b0;
                res_done <= 1'b1;
              end else begin
                mode      <= XL_INV;
                req_ready <= 1'b0;
              end
            end
          end
        end
        XL_FWD: begin
          if (w_cnt_n == tgt_steps) begin
            res_data  <= {1'b0, w_nxt, fine_q};
            res_err   <= 1'b0;
            res_done  <= 1'b1;
            req_ready <= 1'b1;
            mode      <= XL_IDLE;
          end
        end
        XL_INV: begin
          if (w_nxt == tgt_state) begin
            res_data  <= {inv_coarse, fine_q};
            res_err   <= 1'b0;
            res_done  <= 1'b1;
            req_ready <= 1'b1;
            mode      <= XL_IDLE;
          end else if (w_cnt_n == PERIOD) begin
            res_data  <= '0;
            res_err   <= 1'b1;
            res_done  <= 1'b1;
            req_ready <= 1'b1;
            mode      <= XL_IDLE;
          end
        end
        default: begin
          mode      <= XL_IDLE;
          req_ready <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lfsr_div_xlate_chk.sv
module lfsr_div_xlate_chk #(
  parameter int LFSR_W = 11,
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_err,
  input logic              res_done
);
  localparam logic [LFSR_W:0] TBL_N = (LFSR_W+1)'(1 << LFSR_W);

  logic [LFSR_W:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || req_ready) busy_cnt <= '0;
    else if (busy_cnt != TBL_N) busy_cnt <= busy_cnt + 1'b1;
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> req_ready);

  // R8
  accept_only_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid));

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_done && res_err) |-> (res_data == '0));

  // R9
  walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (busy_cnt < TBL_N));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !res_done |-> ($stable(res_data) && $stable(res_err)));
endmodule

bind lfsr_div_xlate lfsr_div_xlate_chk #(
  .LFSR_W(LFSR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .res_data(res_data), .res_err(res_err), .res_done(res_done)
);

// File: tb/lfsr_div_xlate_tb_top.sv
`timescale 1ns/1ps
module lfsr_div_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_inverse = 1'b0;
  logic [13:0] req_data = '0;
  logic        req_ready;
  logic [13:0] res_data;
  logic        res_err;
  logic        res_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  int st_of [2048];
  int idx_of [2048];

  always #10 clk = ~clk;

  lfsr_div_xlate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_inverse(req_inverse),
    .req_data(req_data), .req_ready(req_ready), .res_data(res_data),
    .res_err(res_err), .res_done(res_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input bit inv, input int d, output int q,
                         output int e, output int lat);
    @(negedge clk);
    check("R8 ready before request", int'(req_ready), 1);
    req_valid   = 1'b1;
    req_inverse = inv;
    req_data    = 14'(d);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_done && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    q = int'(res_data);
    e = int'(res_err);
  endtask

  task automatic fwd_case(input int d, input string tag);
    int c, f, k, eq, ee, el, q, e, lat;
    c = d >> 2; f = d & 3;
    if (c < 2 || c >= 2050) begin eq = 0; ee = 1; el = 0; end
    else begin
      k = c - 2;
      if (k == 0) begin eq = f; ee = 0; el = 0; end
      else begin eq = (st_of[k] << 2) | f; ee = 0; el = 2048 - k; end
    end
    run_req(1'b0, d, q, e, lat);
    check({tag, " data"}, q, eq);
    check({tag, " err"}, e, ee);
    check("R9 forward latency", lat, el);
  endtask

  task automatic inv_case(input int d, input string tag);
    int s, f, k, eq, el, q, e, lat;
    s = (d >> 2) & 12'h7ff; f = d & 3;
    if (s == 0) begin eq = 8 + f; el = 0; end
    else begin k = idx_of[s]; eq = ((k + 2) << 2) | f; el = 2048 - k; end
    run_req(1'b1, d, q, e, lat);
    check({tag, " data"}, q, eq);
    check("R7 inverse err", e, 0);
    check("R9 inverse latency", lat, el);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int s;
    int q, e, lat;
    s = 12'h7ff;
    for (int i = 2047; i >= 1; i--) begin
      if (s & 1) s = (s >> 1) ^ 12'h500; else s = s >> 1;
      st_of[i] = s;
      idx_of[s] = i;
    end
    st_of[0] = 0;
    idx_of[0] = 0;

    repeat (3) @(negedge clk);
    check("R10 reset ready", int'(req_ready), 1);
    check("R10 reset done", int'(res_done), 0);
    check("R10 reset data", int'(res_data), 0);
    check("R10 reset err", int'(res_err), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after reset done", int'(res_done), 0);
    check("R10 after reset data", int'(res_data), 0);

    // R1: explicit first and last states
    run_req(1'b0, (2049 << 2) | 1, q, e, lat);
    check("R1 index 2047 state", q, (12'h6ff << 2) | 1);
    run_req(1'b0, (3 << 2) | 2, q, e, lat);
    check("R1 index 1 is seed", q, (12'h7ff << 2) | 2);
    check("R1 index 1 latency", lat, 2047);

    // R3: index zero
    for (int f = 0; f < 4; f++) fwd_case((2 << 2) | f, "R3 index zero");
    // R4: out of range
    fwd_case(0, "R4 low");
    fwd_case(7, "R4 coarse one");
    fwd_case(2050 << 2, "R4 high edge");
    fwd_case(16383, "R4 max");
    fwd_case(8199, "R2 top in range");
    // R2: sweep upper end and mid points
    for (int k = 1900; k < 2048; k++) fwd_case(((k + 2) << 2) | (k & 3), "R2 forward sweep");
    fwd_case(((1024 + 2) << 2) | 3, "R2 forward mid");
    fwd_case(((500 + 2) << 2), "R2 forward low");

    // R6: inverse zero state
    for (int f = 0; f < 4; f++) inv_case(f, "R6 inverse zero");
    inv_case(14'h2000 | 2, "R6 inverse zero bit13");
    // R5: inverse sweep
    for (int k = 1900; k < 2048; k++) inv_case((st_of[k] << 2) | ((k + 1) & 3), "R5 inverse sweep");
    inv_case((st_of[1] << 2) | 1, "R5 inverse seed");
    inv_case(14'h2000 | (st_of[2000] << 2) | 3, "R5 bit13 ignored");
    inv_case((st_of[777] << 2), "R5 inverse mid");

    // R8: requests while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_inverse = 1'b0; req_data = 14'(((1000 + 2) << 2) | 1);
    @(negedge clk);
    req_data = 14'(8 | 3);
    for (int i = 0; i < 5; i++) begin
      check("R8 busy ready low", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    lat = 5;
    while (!res_done && lat < 4000) begin @(negedge clk); lat++; end
    check("R8 busy result kept", int'(res_data), (st_of[1000] << 2) | 1);
    check("R9 busy latency", lat, 1048);
    @(negedge clk);
    check("R9 done single pulse", int'(res_done), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 ignored request no result", int'(res_done), 0);
    end
    check("R8 result held", int'(res_data), (st_of[1000] << 2) | 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule